// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the word address for each cycle of a short memory burst. The host presents a start address together with a load command. On every following cycle that carries an advance command, the block steps an internal burst counter and outputs the next address in the burst. The width of the burst field is a parameter; at the default of two bits, one load gives four beats.

Only the burst field, the lowest address bits, changes during a burst. A static order input selects between two orders. The linear order adds the step count to the start value, modulo the burst length. The interleaved order XORs the start value with the step count. The bits above the burst field hold their loaded value, so a burst never carries into them. After the last beat the sequence wraps to the start value and keeps stepping.

A clock enable freezes all state when it is low. The address and a load-cycle flag are registered, so each command shows up on the outputs one clock after the edge that samples it.

Top module: `burst_addr_gen`

## Requirements
- R1: After synchronous reset, `addr_q` is 0, `load_q` is 0 and the step counter is 0. Advances issued before any load therefore give burst-field values 1, 2, 3, 0 (linear order) above an upper field of zero.
- R2: When `clk_en`=1 and `adv_nload`=0 at an edge, `addr_q` equals the sampled `ext_addr` after that edge, `load_q` is 1 and the step counter restarts at 0.
- R3: When `clk_en`=1 and `adv_nload`=1 at an edge, the step counter increments by one modulo the burst length and `load_q` is 0 after that edge. `ext_addr` is ignored on such a cycle.
- R4: With `order_sel`=0 (linear), the burst field after step n equals (start + n) mod 2^BURST_W.
- R5: With `order_sel`=1 (interleaved), the burst field after step n equals start XOR n.
- R6: After the last beat, the next advance returns the address to the loaded start address, and further advances repeat the sequence.
- R7: The address bits above the burst field keep their loaded value on every advance. There is no carry out of the burst field.
- R8: When `clk_en`=0, `addr_q`, `load_q`, the stored start address and the counter all hold, whatever `adv_nload` and `ext_addr` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | 1 = accept a command this cycle; 0 = freeze |
| adv_nload | input | 1 | 0 = load `ext_addr`; 1 = advance burst |
| order_sel | input | 1 | 0 = linear order; 1 = interleaved order (static) |
| ext_addr | input | ADDR_W | Start address taken on a load |
| addr_q | output | ADDR_W | Registered address of the current beat |
| load_q | output | 1 | Registered flag: current beat came from a load |

## Verification
Assertions check, on every cycle, the following: the freeze under a low clock enable, the capture of the external address on a load, the +1 step of the linear burst field, the fixed upper field during advances, and the counter's restart and increment. The full interleaved sequence and the wrap to the start after the fourth beat are shown only by the bench. So is the defined sequence after reset with no prior load. The bench also shows that a changed external address is ignored while frozen or advancing.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (capture) q <= d;
  end

  assert_start_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(q));
endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               step,
  output logic [BURST_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (restart) count <= '0;
    else if (step)    count <= count + BURST_W'(1);
  end

  assert_ctr_restart_R2: assert property (@(posedge clk) disable iff (rst)
    restart |=> count == '0);
  assert_ctr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !restart) |=> count == $past(count) + BURST_W'(1));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] start_low,
  input  logic [BURST_W-1:0] step_idx,
  input  logic               order_sel,
  output logic [BURST_W-1:0] beat_low
);
  always_comb begin
    if (burst_order_e'(order_sel) == ORDER_INTERLEAVE)
      beat_low = start_low ^ step_idx;
    else
      beat_low = start_low + step_idx;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              adv_nload,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              load_q
);
  localparam int UP_W = ADDR_W - BURST_W;

  logic               do_load, do_step;
  logic [ADDR_W-1:0]  start_addr, next_start;
  logic [BURST_W-1:0] count, next_count, next_low;

  assign do_load = clk_en && !adv_nload;
  assign do_step = clk_en &&  adv_nload;

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk(clk), .rst(rst), .capture(do_load), .d(ext_addr), .q(start_addr)
  );

  burst_step_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk(clk), .rst(rst), .restart(do_load), .step(do_step), .count(count)
  );

  assign next_start = do_load ? ext_addr : start_addr;
  assign next_count = do_load ? '0 : count + BURST_W'(1);

  burst_order_map #(.BURST_W(BURST_W)) u_map (
    .start_low(next_start[BURST_W-1:0]), .step_idx(next_count),
    .order_sel(order_sel), .beat_low(next_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      load_q <= 1'b0;
    end else if (clk_en) begin
      addr_q <= {next_start[ADDR_W-1:BURST_W], next_low};
      load_q <= !adv_nload;
    end
  end

  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(addr_q) && $stable(load_q));
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    do_load |=> (addr_q == $past(ext_addr)) && load_q);
  assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
    do_step |=> addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W]) && !load_q);
  assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
    (do_step && !order_sel) |=>
      addr_q[BURST_W-1:0] == $past(addr_q[BURST_W-1:0]) + BURST_W'(1));
  assert_up_width_ok: assert property (@(posedge clk) UP_W > 0);
endmodule

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int AW = 18;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst, clk_en, adv_nload, order_sel;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] addr_q;
  logic          load_q;

  int n_tests = 0;
  int n_fail  = 0;

  logic [AW-1:0] m_start = '0;
  logic [BW-1:0] m_cnt   = '0;
  logic [AW-1:0] m_addr  = '0;
  logic          m_flag  = 1'b0;

  burst_addr_gen #(.ADDR_W(AW), .BURST_W(BW)) dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .adv_nload(adv_nload),
    .order_sel(order_sel), .ext_addr(ext_addr), .addr_q(addr_q), .load_q(load_q)
  );

  always #10 clk = ~clk;

  function automatic logic [BW-1:0] beat(input logic [BW-1:0] s, input logic [BW-1:0] n,
                                         input logic inter);
    return inter ? (s ^ n) : (s + n);
  endfunction

  task automatic check(input logic [AW-1:0] exp_a, input logic exp_f, input string tag);
    n_tests++;
    if (addr_q !== exp_a || load_q !== exp_f) begin
      n_fail++;
      $display("FAIL %s: addr=%h flag=%b expected addr=%h flag=%b",
               tag, addr_q, load_q, exp_a, exp_f);
    end
  endtask

  task automatic cycle(input logic en, input logic adv, input logic [AW-1:0] a,
                       input logic ord);
    clk_en = en; adv_nload = adv; ext_addr = a; order_sel = ord;
    @(posedge clk);
    if (en) begin
      if (!adv) begin
        m_start = a; m_cnt = '0; m_addr = a; m_flag = 1'b1;
      end else begin
        m_cnt = m_cnt + 1'b1;
        m_addr = {m_start[AW-1:BW], beat(m_start[BW-1:0], m_cnt, ord)};
        m_flag = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ord;
    logic [AW-1:0] a;
    void'($urandom(32'd2024));
    rst = 1'b1; clk_en = 1'b0; adv_nload = 1'b1; order_sel = 1'b0; ext_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check('0, 1'b0, "R1 reset");

    // R1: advance with no prior load walks 1,2,3,0
    for (int i = 1; i <= 4; i++) begin
      cycle(1'b1, 1'b1, 18'h3FFFF, 1'b0);
      check(AW'(i % 4), 1'b0, "R1 advance from reset");
    end

    // R2/R4/R6 linear from low 2: 2,3,0,1,2
    cycle(1'b1, 1'b0, 18'h0002A, 1'b0);
    check(18'h0002A, 1'b1, "R2 load");
    cycle(1'b1, 1'b1, 18'h11111, 1'b0); check(18'h0002B, 1'b0, "R3 R4 linear step1");
    cycle(1'b1, 1'b1, 18'h11111, 1'b0); check(18'h00028, 1'b0, "R4 linear step2");
    cycle(1'b1, 1'b1, 18'h11111, 1'b0); check(18'h00029, 1'b0, "R4 linear step3");
    cycle(1'b1, 1'b1, 18'h11111, 1'b0); check(18'h0002A, 1'b0, "R6 wrap linear");
    cycle(1'b1, 1'b1, 18'h11111, 1'b0); check(18'h0002B, 1'b0, "R6 continue after wrap");

    // R5 interleaved from low 1: 1,0,3,2,1
    cycle(1'b1, 1'b0, 18'h12341, 1'b1); check(18'h12341, 1'b1, "R2 load interleaved");
    cycle(1'b1, 1'b1, 18'h0, 1'b1); check(18'h12340, 1'b0, "R5 interleave step1");
    cycle(1'b1, 1'b1, 18'h0, 1'b1); check(18'h12343, 1'b0, "R5 interleave step2");
    cycle(1'b1, 1'b1, 18'h0, 1'b1); check(18'h12342, 1'b0, "R5 interleave step3");
    cycle(1'b1, 1'b1, 18'h0, 1'b1); check(18'h12341, 1'b0, "R6 wrap interleaved");

    // R7 no carry out of burst field
    cycle(1'b1, 1'b0, 18'h3FFFF, 1'b0); check(18'h3FFFF, 1'b1, "R2 load top");
    cycle(1'b1, 1'b1, 18'h0, 1'b0); check(18'h3FFFC, 1'b0, "R7 no carry");

    // R8 freeze ignores load command and new address
    for (int i = 0; i < 3; i++) begin
      cycle(1'b0, 1'b0, 18'h05555, 1'b0);
      check(18'h3FFFC, 1'b0, "R8 freeze");
    end
    cycle(1'b1, 1'b1, 18'h0, 1'b0); check(18'h3FFFD, 1'b0, "R8 counter held");

    // random mix against model
    m_start = 18'h3FFFF; m_cnt = 2'd2; m_addr = 18'h3FFFD; m_flag = 1'b0;
    ord = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic en, adv;
      en  = ($urandom % 5) != 0;
      adv = ($urandom % 4) != 0;
      a   = AW'($urandom);
      if (en && !adv) ord = 1'($urandom);
      cycle(en, adv, a, ord);
      check(m_addr, m_flag, ord ? "R5 R3 random" : "R4 R3 random");
    end

    // reset mid-burst
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    check('0, 1'b0, "R1 reset again");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule